// File: doc/BRIEF.md
# Banked MDIO Management Master

This block is a memory-mapped station-management master that serves a bank of downstream MDIO buses: sixteen on the internal side and sixteen on the external side. Software loads a parameter word that picks the target bus, the framing style (Clause 22 or Clause 45), the PHY or port address and any write data. It then loads a register address and writes an operation code to the control register. The block runs the whole management transaction on the chosen bus, returns read data in a dedicated register, and reports completion through a done flag.

A single MDC clock, divided down from the system clock, is shared by all buses. Each bus has its own data-out, output-enable and data-in lines. Only the selected bus is driven, and only its input is listened to. In Clause 45 mode the block sends an address frame followed by a data frame, with no software action between them. The register port is a plain single-cycle write strobe with a combinational read mux, so there is no back-pressure on it.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset the status and read-data registers read 0, MDC is low and every output enable is low.
- R2: Register offsets are 0x23C (parameter), 0x240 (read data), 0x244 (register address), 0x248 (control) and 0x24C (status, bit 0 = done). The parameter register keeps bits 26:0 and the address register keeps bits 20:0. Unkept bits read as 0.
- R3: A control write of 1 starts a write and a control write of 2 starts a read. Any other value starts nothing. Any control write accepted while idle clears done.
- R4: Done becomes 1 when the last frame of a transaction ends and holds until the next accepted control write. Done is 0 while a transaction runs.
- R5: A Clause 22 frame is sent MSB first on rising MDC edges as: 32 ones, start 01, opcode (01 write, 10 read), PHY address = parameter[20:16], register address = address[4:0], turnaround 10, then 16 data bits (parameter[15:0] on a write).
- R6: On a read, the output enable is low for the last 18 bit times of the read frame (turnaround and data). The 16 bits sampled on the last 16 rising edges are returned MSB first in read-data bits 15:0.
- R7: With parameter bit 21 set, the block first sends an address frame (start 00, opcode 00, port = parameter[20:16], device = address[20:16], turnaround 10, data = address[15:0]). It then sends a frame with start 00, opcode 11 (read) or 01 (write), the same port and device, and the data as in R5 and R6.
- R8: Parameter bit 26 = 1 selects internal bus parameter[25:22], and 0 selects the external bus with that number. Only the selected bus's output enable can be high. The data inputs of all other buses have no effect.
- R9: MDC is low when idle and has a period of 2·HALF system clocks while running. Data out and output enable change only while MDC is low, and input is sampled at MDC rising edges.
- R10: A start written while a transaction runs is ignored, and register writes made during a transaction do not change its bus, frames or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe, one cycle per write |
| cpu_addr | input | ADDR_W | Byte offset of the register accessed |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational on cpu_addr) |
| mdc | output | 1 | Management clock shared by all buses |
| int_mdo | output | NBUS | Internal bus data out (1 when not selected) |
| int_oe | output | NBUS | Internal bus output enable |
| int_mdi | input | NBUS | Internal bus data in |
| ext_mdo | output | NBUS | External bus data out (1 when not selected) |
| ext_oe | output | NBUS | External bus output enable |
| ext_mdi | input | NBUS | External bus data in |

## Verification
The properties assume that HALF is at least 2, so that MDC stays high for more than one system clock. They also assume that writes arrive as single-cycle strobes at offsets inside the window. The bench keeps HALF at 2 and issues every register access through one write task and one read task. It drives the unselected buses' inputs with the inverse of the responder bit, so that any leak into the captured data shows up in the read result. It changes the bus inputs only on MDC falling edges, which matches the sampling rule the checker relies on.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;

  localparam int FRAME_W   = 64;
  localparam int PARAM_W   = 27;
  localparam int AREG_W    = 21;
  localparam int RD_DRV_W  = 46;

  localparam logic [1:0] ST_C22   = 2'b01;
  localparam logic [1:0] ST_C45   = 2'b00;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD22  = 2'b10;
  localparam logic [1:0] OP_RD45  = 2'b11;
  localparam logic [1:0] OP_ADDR  = 2'b00;

  localparam logic [FRAME_W-1:0] RD_OE_MASK =
    {{RD_DRV_W{1'b1}}, {(FRAME_W-RD_DRV_W){1'b0}}};

  localparam logic [31:0] CMD_WRITE = 32'd1;
  localparam logic [31:0] CMD_READ  = 32'd2;

  typedef struct packed {
    logic              is_read;
    logic              c45;
    logic              internal;
    logic [3:0]        bus;
    logic [4:0]        phy;
    logic [15:0]       wdata;
    logic [AREG_W-1:0] addr;
  } mdio_cmd_t;

  function automatic logic [FRAME_W-1:0] mk_frame(
    input logic [1:0] st, input logic [1:0] op,
    input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

endpackage

// File: rtl/mdio_mux_regs.sv
module mdio_mux_regs
  import mdio_mux_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic              rd_valid,
  input  logic [15:0]       rd_data,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic              done
);

  localparam logic [ADDR_W-1:0] OFF_PARAM = ADDR_W'('h23C);
  localparam logic [ADDR_W-1:0] OFF_RDATA = ADDR_W'('h240);
  localparam logic [ADDR_W-1:0] OFF_AREG  = ADDR_W'('h244);
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'('h248);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'('h24C);

  logic [PARAM_W-1:0] param_q;
  logic [AREG_W-1:0]  areg_q;
  logic [15:0]        rdata_q;
  logic               done_q;
  logic               ctrl_wr;

  assign ctrl_wr = cpu_we && (cpu_addr == OFF_CTRL) && !busy;
  assign start   = ctrl_wr && ((cpu_wdata == CMD_WRITE) || (cpu_wdata == CMD_READ));
  assign done    = done_q;

  always_comb begin
    cmd.is_read  = (cpu_wdata == CMD_READ);
    cmd.internal = param_q[26];
    cmd.bus      = param_q[25:22];
    cmd.c45      = param_q[21];
    cmd.phy      = param_q[20:16];
    cmd.wdata    = param_q[15:0];
    cmd.addr     = areg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      param_q <= '0;
      areg_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (cpu_we && cpu_addr == OFF_PARAM) param_q <= cpu_wdata[PARAM_W-1:0];
      if (cpu_we && cpu_addr == OFF_AREG)  areg_q  <= cpu_wdata[AREG_W-1:0];
      if (rd_valid) rdata_q <= rd_data;
      if (xfer_done)    done_q <= 1'b1;
      else if (ctrl_wr) done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (cpu_addr)
      OFF_PARAM: cpu_rdata = {{(32-PARAM_W){1'b0}}, param_q};
      OFF_RDATA: cpu_rdata = {16'd0, rdata_q};
      OFF_AREG:  cpu_rdata = {{(32-AREG_W){1'b0}}, areg_q};
      OFF_STAT:  cpu_rdata = {31'd0, done_q};
      default:   cpu_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/mdio_mux_clkgen.sv
module mdio_mux_clkgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run && (cnt_q == CW'(HALF - 1));
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_mux_engine.sv
module mdio_mux_engine
  import mdio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdi,
  output logic        run,
  output logic        mdo,
  output logic        oe,
  output logic        xfer_done,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        sel_int,
  output logic [3:0]  sel_bus
);

  localparam int BW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, oe_q, f2_q;
  logic [FRAME_W-1:0] f1, m1, f2;
  logic [BW-1:0]      bit_q;
  logic               pend_q, run_q, rd_q, int_q;
  logic [3:0]         bus_q;
  logic [15:0]        cap_q;
  logic               last;

  always_comb begin
    if (cmd.c45)
      f1 = mk_frame(ST_C45, OP_ADDR, cmd.phy, cmd.addr[20:16], cmd.addr[15:0]);
    else
      f1 = mk_frame(ST_C22, cmd.is_read ? OP_RD22 : OP_WR, cmd.phy,
                    cmd.addr[4:0], cmd.wdata);
    m1 = (cmd.is_read && !cmd.c45) ? RD_OE_MASK : '1;
    f2 = mk_frame(ST_C45, cmd.is_read ? OP_RD45 : OP_WR, cmd.phy,
                  cmd.addr[20:16], cmd.wdata);
  end

  assign last      = (bit_q == BW'(FRAME_W - 1));
  assign xfer_done = run_q && fall && last && !pend_q;
  assign rd_valid  = xfer_done && rd_q;
  assign rd_data   = cap_q;
  assign run       = run_q;
  assign mdo       = run_q ? sh_q[FRAME_W-1] : 1'b1;
  assign oe        = run_q && oe_q[FRAME_W-1];
  assign sel_int   = int_q;
  assign sel_bus   = bus_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0; oe_q <= '0; f2_q <= '0;
      bit_q <= '0; pend_q <= 1'b0; run_q <= 1'b0;
      rd_q <= 1'b0; int_q <= 1'b0; bus_q <= '0; cap_q <= '0;
    end else if (start && !run_q) begin
      sh_q   <= f1;
      oe_q   <= m1;
      f2_q   <= f2;
      bit_q  <= '0;
      pend_q <= cmd.c45;
      run_q  <= 1'b1;
      rd_q   <= cmd.is_read;
      int_q  <= cmd.internal;
      bus_q  <= cmd.bus;
    end else if (run_q) begin
      if (rise) cap_q <= {cap_q[14:0], mdi};
      if (fall) begin
        if (last) begin
          if (pend_q) begin
            sh_q   <= f2_q;
            oe_q   <= rd_q ? RD_OE_MASK : '1;
            bit_q  <= '0;
            pend_q <= 1'b0;
          end else begin
            run_q <= 1'b0;
          end
        end else begin
          sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
          oe_q  <= {oe_q[FRAME_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mdio_mux_fanout.sv
module mdio_mux_fanout #(
  parameter int NBUS = 16
) (
  input  logic            sel_int,
  input  logic [3:0]      sel_bus,
  input  logic            mdo,
  input  logic            oe,
  output logic            mdi,
  output logic [NBUS-1:0] int_mdo,
  output logic [NBUS-1:0] int_oe,
  input  logic [NBUS-1:0] int_mdi,
  output logic [NBUS-1:0] ext_mdo,
  output logic [NBUS-1:0] ext_oe,
  input  logic [NBUS-1:0] ext_mdi
);

  logic [NBUS-1:0] hit_int, hit_ext;

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    assign hit_int[i] = sel_int  && (sel_bus == 4'(i));
    assign hit_ext[i] = !sel_int && (sel_bus == 4'(i));
    assign int_oe[i]  = oe && hit_int[i];
    assign ext_oe[i]  = oe && hit_ext[i];
    assign int_mdo[i] = hit_int[i] ? mdo : 1'b1;
    assign ext_mdo[i] = hit_ext[i] ? mdo : 1'b1;
  end

  assign mdi = (|(int_mdi & hit_int)) | (|(ext_mdi & hit_ext));

endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
  import mdio_mux_pkg::*;
#(
  parameter int NBUS   = 16,
  parameter int HALF   = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              mdc,
  output logic [NBUS-1:0]   int_mdo,
  output logic [NBUS-1:0]   int_oe,
  input  logic [NBUS-1:0]   int_mdi,
  output logic [NBUS-1:0]   ext_mdo,
  output logic [NBUS-1:0]   ext_oe,
  input  logic [NBUS-1:0]   ext_mdi
);

  mdio_cmd_t   cmd;
  logic        start, busy, done, xfer_done, rd_valid;
  logic [15:0] rd_data;
  logic        rise, fall, mdo, oe, mdi, sel_int;
  logic [3:0]  sel_bus;

  mdio_mux_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .busy, .xfer_done, .rd_valid, .rd_data, .start, .cmd, .done
  );

  mdio_mux_clkgen #(.HALF(HALF)) u_clk (
    .clk, .rst_n, .run(busy), .mdc, .rise, .fall
  );

  mdio_mux_engine u_eng (
    .clk, .rst_n, .start, .cmd, .rise, .fall, .mdi,
    .run(busy), .mdo, .oe, .xfer_done, .rd_valid, .rd_data,
    .sel_int, .sel_bus
  );

  mdio_mux_fanout #(.NBUS(NBUS)) u_fan (
    .sel_int, .sel_bus, .mdo, .oe, .mdi,
    .int_mdo, .int_oe, .int_mdi, .ext_mdo, .ext_oe, .ext_mdi
  );

endmodule

// File: rtl/mdio_mux_master_chk.sv
module mdio_mux_master_chk #(
  parameter int NBUS   = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [31:0]       cpu_wdata,
  input logic              mdc,
  input logic [NBUS-1:0]   int_mdo,
  input logic [NBUS-1:0]   int_oe,
  input logic [NBUS-1:0]   ext_mdo,
  input logic [NBUS-1:0]   ext_oe,
  input logic              busy,
  input logic              done
);

  logic ctrl_idle_nostart;
  assign ctrl_idle_nostart = cpu_we && (cpu_addr == ADDR_W'('h248)) && !busy &&
                             (cpu_wdata != 32'd1) && (cpu_wdata != 32'd2);

  // R8: at most one enable across both banks
  a_r8_single_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_oe, ext_oe}));

  // R9: management clock parked low when idle
  a_r9_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9: bus outputs frozen while MDC is high
  a_r9_mdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable({int_mdo, ext_mdo}) && $stable({int_oe, ext_oe})));

  // R4: done is never set during a running transaction
  a_r4_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R4: done rises only as a transaction ends
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R3: a non-start control write while idle clears done
  a_r3_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle_nostart |=> !done);

endmodule

bind mdio_mux_master mdio_mux_master_chk #(.NBUS(NBUS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .mdc(mdc), .int_mdo(int_mdo), .int_oe(int_oe),
  .ext_mdo(ext_mdo), .ext_oe(ext_oe), .busy(busy), .done(done)
);

// File: tb/sim_mdio_mux_master.sv
module sim_mdio_mux_master;

  localparam int CLK_P  = 10;
  localparam int HALF   = 2;
  localparam int NBUS   = 16;
  localparam int ADDR_W = 10;
  localparam logic [63:0] RDM = {{46{1'b1}}, {18{1'b0}}};

  // {rd, c45, internal, bus[3:0], phy[4:0], addr[20:0], wdata[15:0], rsp[15:0]}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 4'd3,  5'd5,  21'h0000A, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 1'b1, 4'd15, 5'd31, 21'h0001F, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 1'b0, 4'd0,  5'd1,  21'h00003, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 1'b0, 4'd9,  5'd0,  21'h00000, 16'h0000, 16'h0001},
    {1'b0, 1'b1, 1'b1, 4'd7,  5'd3,  {5'h1E, 16'hC0DE}, 16'h5A5A, 16'h0000},
    {1'b1, 1'b1, 1'b0, 4'd14, 5'd18, {5'h07, 16'h0102}, 16'h0000, 16'h8421}
  };

  logic clk = 1'b0, rst_n = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic mdc;
  logic [NBUS-1:0] int_mdo, int_oe, ext_mdo, ext_oe, int_mdi, ext_mdi;
  logic [31:0] all_mdi = '0;
  logic [31:0] all_mdo, all_oe;

  int checks = 0, errors = 0;
  int sel_idx = 0, rcount = 0, nfr = 0, other_oe = 0, kk = 0;
  logic [15:0] rsp = '0;
  logic [63:0] fr_sh = '0, oe_sh = '0;
  logic [63:0] frames [4];
  logic [63:0] masks [4];
  time t_r0 = 0, t_r1 = 0;
  logic rb;

  assign all_mdo = {ext_mdo, int_mdo};
  assign all_oe  = {ext_oe, int_oe};
  assign int_mdi = all_mdi[15:0];
  assign ext_mdi = all_mdi[31:16];

  always #(CLK_P/2) clk = ~clk;

  mdio_mux_master #(.NBUS(NBUS), .HALF(HALF), .ADDR_W(ADDR_W)) u0 (
    .clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .mdc,
    .int_mdo, .int_oe, .int_mdi, .ext_mdo, .ext_oe, .ext_mdi
  );

  // bus monitor: records each bit at the MDC rising edge
  always @(posedge mdc) begin
    fr_sh = {fr_sh[62:0], all_mdo[sel_idx]};
    oe_sh = {oe_sh[62:0], all_oe[sel_idx]};
    other_oe = other_oe + $countones(all_oe) - int'(all_oe[sel_idx]);
    if (rcount == 0) t_r0 = $time;
    if (rcount == 1) t_r1 = $time;
    rcount = rcount + 1;
    if (rcount % 64 == 0 && nfr < 4) begin
      frames[nfr] = fr_sh;
      masks[nfr]  = oe_sh;
      nfr = nfr + 1;
    end
  end

  // responder: selected bus gets rsp in the data window, others the inverse
  always @(negedge mdc) begin
    kk = rcount % 64;
    rb = (kk >= 48) ? rsp[63-kk] : 1'b1;
    all_mdi = {32{~rb}};
    all_mdi[sel_idx] = rb;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      rd(10'h24C, s);
      if (s[0]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [63:0] ef(input logic [1:0] st, input logic [1:0] op,
    input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] pword(input logic [64:0] v);
    return {5'd0, v[62], v[61:58], v[63], v[57:53], v[31:16]};
  endfunction

  task automatic arm(input logic [64:0] v);
    sel_idx = v[62] ? int'(v[61:58]) : 16 + int'(v[61:58]);
    rsp = v[15:0];
    rcount = 0; nfr = 0; other_oe = 0;
  endtask

  task automatic run_vec(input logic [64:0] v);
    logic [31:0] r;
    logic [63:0] e0, e1, mk0, mk1;
    bit ok;
    logic rdop, c45;
    rdop = v[64]; c45 = v[63];
    arm(v);
    wr(10'h23C, pword(v));
    wr(10'h244, {11'd0, v[52:32]});
    wr(10'h248, 32'd0);
    rd(10'h24C, r);
    check(r[0] == 1'b0, "R3 done cleared by control 0", 64'(r[0]), 0);
    wr(10'h248, rdop ? 32'd2 : 32'd1);
    wait_done(ok);
    check(ok, "R4 done after transaction", 64'(ok), 1);
    if (!c45) begin
      e0  = ef(2'b01, rdop ? 2'b10 : 2'b01, v[57:53], v[36:32], rdop ? 16'h0 : v[31:16]);
      mk0 = rdop ? RDM : '1;
      check(nfr == 1, "R5 one frame", 64'(nfr), 1);
      check((frames[0] & mk0) == (e0 & mk0), "R5 frame bits", frames[0], e0);
      check(masks[0] == mk0, "R6 drive window", masks[0], mk0);
    end else begin
      e0  = ef(2'b00, 2'b00, v[57:53], v[52:48], v[47:32]);
      e1  = ef(2'b00, rdop ? 2'b11 : 2'b01, v[57:53], v[52:48], rdop ? 16'h0 : v[31:16]);
      mk1 = rdop ? RDM : '1;
      check(nfr == 2, "R7 two frames", 64'(nfr), 2);
      check(frames[0] == e0 && masks[0] == '1, "R7 address frame", frames[0], e0);
      check((frames[1] & mk1) == (e1 & mk1) && masks[1] == mk1, "R7 data frame",
            frames[1], e1);
    end
    check(other_oe == 0, "R8 only selected bus driven", 64'(other_oe), 0);
    if (rdop) begin
      rd(10'h240, r);
      check(r == {16'd0, v[15:0]}, "R6 R8 read data captured", 64'(r), 64'(v[15:0]));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(10'h24C, r); check(r == 0, "R1 status after reset", 64'(r), 0);
    rd(10'h240, r); check(r == 0, "R1 read data after reset", 64'(r), 0);
    check(mdc == 1'b0 && all_oe == 0, "R1 idle bus", 64'({mdc, all_oe}), 0);

    // R2 readback masks
    wr(10'h23C, 32'hFFFF_FFFF); rd(10'h23C, r);
    check(r == 32'h07FF_FFFF, "R2 parameter readback", 64'(r), 64'h07FF_FFFF);
    wr(10'h244, 32'hFFFF_FFFF); rd(10'h244, r);
    check(r == 32'h001F_FFFF, "R2 address readback", 64'(r), 64'h001F_FFFF);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9 MDC period measured on the last transaction
    check((t_r1 - t_r0) == 2 * HALF * CLK_P, "R9 MDC period",
          64'(t_r1 - t_r0), 64'(2 * HALF * CLK_P));
    check(mdc == 1'b0, "R9 MDC low when idle", 64'(mdc), 0);

    // R4 done holds until a control write
    repeat (40) @(negedge clk);
    rd(10'h24C, r); check(r[0] == 1'b1, "R4 done holds", 64'(r[0]), 1);

    // R3 unsupported opcode starts nothing
    wr(10'h248, 32'd0);
    rcount = 0;
    wr(10'h248, 32'd3);
    repeat (200) @(negedge clk);
    check(rcount == 0 && all_oe == 0, "R3 opcode 3 ignored", 64'(rcount), 0);
    rd(10'h24C, r); check(r[0] == 1'b0, "R3 no done after opcode 3", 64'(r[0]), 0);

    // R10 start and parameter changes ignored while running
    arm({1'b0, 1'b0, 1'b1, 4'd2, 5'd4, 21'h6, 16'h0F0F, 16'h0});
    wr(10'h23C, pword({1'b0, 1'b0, 1'b1, 4'd2, 5'd4, 21'h6, 16'h0F0F, 16'h0}));
    wr(10'h244, 32'h6);
    wr(10'h248, 32'd1);
    repeat (100) @(negedge clk);
    wr(10'h23C, pword({1'b1, 1'b0, 1'b0, 4'd5, 5'd9, 21'h1, 16'hAAAA, 16'h0}));
    wr(10'h244, 32'h1);
    wr(10'h248, 32'd2);
    wait_done(ok);
    check(ok && nfr == 1, "R10 single transaction", 64'(nfr), 1);
    check(frames[0] == ef(2'b01, 2'b01, 5'd4, 5'd6, 16'h0F0F), "R10 frame unchanged",
          frames[0], ef(2'b01, 2'b01, 5'd4, 5'd6, 16'h0F0F));
    check(other_oe == 0, "R10 R8 bus kept", 64'(other_oe), 0);
    repeat (300) @(negedge clk);
    check(nfr == 1, "R10 no late start", 64'(nfr), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule